// File: doc/BRIEF.md
# NOR Flash Block Erase Sequencer

This block drives the erase of NOR flash blocks that use the extended command set. A request carries a byte address, a permitted window `[rangeLo, rangeHi)` and a mode bit. In single mode one block is erased. In range mode every block from `rangeLo` up to `rangeHi` is erased in turn. Block edges come from a geometry table of up to `NREG` regions. Each region has a block count and a power-of-two block size, and the regions lie back to back from byte 0.

Each erase runs as follows:
- The programming-voltage enable is raised.
- The setup and confirm commands are written to the block's word address.
- The status is polled until every chip lane reports ready, or until a timeout that is derived from `CLK_HZ` and `TIMEOUT_MS`.
- The enable is dropped.
- Status is cleared and the flash is returned to read-array mode.

The result is reported per lane as a 3-bit code. The codes are: 0 ok, 1 range/alignment reject, 2 boot-protect reject, 3 block locked, 4 low programming voltage, 5 program/erase failure, 6 timeout.

Chip lanes are 8 bits wide. `LANES` chips are interleaved, so one bus word is `LANES` bytes and the word address is the byte address shifted right by `log2(LANES)`. Commands are replicated into every lane.

Top module: `flash_erase_seq`

## Requirements
- R1: Each erase writes 0x20 and then 0xD0 on consecutive cycles, each replicated in every byte lane, at word address `byteAddr >> log2(LANES)` of the block start. `vppEn` is high for one cycle before the 0x20 write and stays high through both writes.
- R2: After the confirm write the block reads status once per cycle (`flashRe` high). Read data is valid in the same cycle. Polling ends on the first read in which bit 7 is set in every lane.
- R3: If no read shows ready within `CLK_HZ/1000*TIMEOUT_MS` reads, polling stops after exactly that many reads and every lane field reports code 6.
- R4: Region r starts at the sum of count×size of regions below r, and only regions below `geoCount` exist. The block start of an address is `base + floor((addr-base)/size)*size` in the first region holding it, or all ones if no region holds it. A request whose target is outside `[rangeLo, rangeHi)` or is not a block start gets code 1 and no erase.
- R5: In range mode the target starts at `rangeLo` and advances to the current block's end after each good erase, stopping when that end is at or above `rangeHi`.
- R6: With `bootProtect` high, a target inside the first block of region 0, or any target while `geoCount` is 0, gets code 2 and no erase. This check takes priority over R4.
- R7: Each lane's status byte is classified in priority order: bit 1 gives 3, then bit 3 gives 4, then bit 4 or 5 gives 5, otherwise 0. Lane l reports in `errCodes[3l+2:3l]`.
- R8: When polling ends, `vppEn` falls, and then 0x50 and 0xFF are written to the same word address on consecutive cycles with `vppEn` low.
- R9: A range walk stops after the first block with a nonzero lane code. `done` is a one-cycle pulse at the end of every request. `errCodes` holds the result until the next accepted start.
- R10: `start` is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `vppEn`, `flashWe`, `flashRe` and `errCodes` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when idle |
| wholeRange | input | 1 | 1 = erase whole range, 0 = single block |
| reqAddr | input | AW | Byte address of the single block |
| rangeLo | input | AW | Inclusive window start |
| rangeHi | input | AW | Exclusive window end |
| bootProtect | input | 1 | Enables the boot-block guard |
| geoCount | input | CW | Number of valid regions |
| geoLog2 | input | NREG*LOGW | Per-region log2 of block size in bytes |
| geoNum | input | NREG*CNTW | Per-region block count |
| flashWe | output | 1 | Bus write strobe |
| flashRe | output | 1 | Bus read strobe |
| flashAddr | output | AW-log2(LANES) | Word address |
| flashWdata | output | 8*LANES | Write data (mirrored command) |
| flashRdata | input | 8*LANES | Read data, valid with flashRe |
| vppEn | output | 1 | Programming-voltage enable |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| errCodes | output | 3*LANES | Per-lane result codes |

## Verification
The assertions assume that the range window, the protect bit and the geometry inputs stay constant while `busy` is high. They also assume that every region block size is smaller than the address space, so that a block end compares above its start. The bench changes these inputs only in the idle cycle before a pulse on `start`. It uses one fixed three-region table whose blocks sum to well under the 16-bit address space.

The flash model answers status within the same cycle as a read. It lets the bench set a ready delay and injected error bits per lane, so each lane can be driven independently.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_RANGE = 3'd1,
    ERR_BOOT  = 3'd2,
    ERR_LOCK  = 3'd3,
    ERR_VOLT  = 3'd4,
    ERR_FAIL  = 3'd5,
    ERR_TIME  = 3'd6
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_VPP, S_SETUP, S_CONFIRM,
    S_POLL, S_CLEAR, S_READARR, S_NEXT, S_DONE
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic advance;
    logic timerClr;
    logic timerInc;
    logic takeStatus;
    logic takeTimeout;
    logic takeReject;
  } dp_strobe_t;

  localparam logic [7:0] CMD_SETUP   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_READ    = 8'hFF;

  // per-lane status byte classification, R7 priority order
  function automatic err_e classify(input logic [7:0] s);
    if (s[1])             return ERR_LOCK;
    else if (s[3])        return ERR_VOLT;
    else if (s[4] | s[5]) return ERR_FAIL;
    else                  return ERR_NONE;
  endfunction

endpackage

// File: rtl/flash_erase_geom.sv
module flash_erase_geom #(
  parameter int AW   = 24,
  parameter int NREG = 4,
  parameter int LOGW = 5,
  parameter int CNTW = 8,
  parameter int CW   = 3
) (
  input  logic [AW-1:0]        addr,
  input  logic [CW-1:0]        geoCount,
  input  logic [NREG*LOGW-1:0] geoLog2,
  input  logic [NREG*CNTW-1:0] geoNum,
  output logic [AW-1:0]        blkStart,
  output logic [AW-1:0]        blkEnd,
  output logic                 bootHit
);

  logic [AW-1:0]   regBase [NREG+1];
  logic [NREG-1:0] hit;

  assign regBase[0] = '0;

  for (genvar i = 0; i < NREG; i++) begin : g_region
    logic [LOGW-1:0] lg;
    logic [AW-1:0]   span;
    assign lg   = geoLog2[i*LOGW +: LOGW];
    assign span = AW'(geoNum[i*CNTW +: CNTW]) << lg;
    assign regBase[i+1] = regBase[i] + span;
    assign hit[i] = (CW'(i) < geoCount) && (addr >= regBase[i]) && (addr < regBase[i+1]);
  end

  logic [LOGW-1:0] lgSel;
  logic [AW-1:0]   offs;

  // lowest matching region wins
  always_comb begin
    blkStart = '1;
    blkEnd   = '1;
    lgSel    = '0;
    offs     = '0;
    for (int i = NREG-1; i >= 0; i--) begin
      if (hit[i]) begin
        lgSel    = geoLog2[i*LOGW +: LOGW];
        offs     = addr - regBase[i];
        blkStart = regBase[i] + ((offs >> lgSel) << lgSel);
        blkEnd   = blkStart + (AW'(1) << lgSel);
      end
    end
  end

  assign bootHit = (geoCount != '0) && (geoNum[CNTW-1:0] != '0) &&
                   (addr < (AW'(1) << geoLog2[LOGW-1:0]));

endmodule

// File: rtl/flash_erase_dp.sv
module flash_erase_dp
  import flash_erase_pkg::*;
#(
  parameter int AW      = 24,
  parameter int LANES   = 2,
  parameter int NREG    = 4,
  parameter int LOGW    = 5,
  parameter int CNTW    = 8,
  parameter int CW      = 3,
  parameter int TMO_CYC = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_strobe_t           ctl,
  input  logic [AW-1:0]        reqAddr,
  input  logic                 wholeReq,
  input  logic [AW-1:0]        rangeLo,
  input  logic [AW-1:0]        rangeHi,
  input  logic                 bootProtect,
  input  logic [CW-1:0]        geoCount,
  input  logic [NREG*LOGW-1:0] geoLog2,
  input  logic [NREG*CNTW-1:0] geoNum,
  input  logic [8*LANES-1:0]   flashRdata,
  output logic [AW-$clog2(LANES)-1:0] curWord,
  output err_e                 checkCode,
  output logic                 lanesReady,
  output logic                 timerDone,
  output logic                 anyError,
  output logic                 walkEnd,
  output logic                 wholeMode,
  output logic [3*LANES-1:0]   errCodes
);

  localparam int WS = $clog2(LANES);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [AW-1:0]      curAddr;
  logic [TW-1:0]      pollCnt;
  logic [3*LANES-1:0] errReg;
  logic [3*LANES-1:0] laneCodes;
  logic [LANES-1:0]   laneRdy;
  logic [AW-1:0]      blkStart, blkEnd;
  logic               bootHit, bootReject, inRange;

  flash_erase_geom #(
    .AW(AW), .NREG(NREG), .LOGW(LOGW), .CNTW(CNTW), .CW(CW)
  ) u_geom (
    .addr(curAddr), .geoCount(geoCount), .geoLog2(geoLog2), .geoNum(geoNum),
    .blkStart(blkStart), .blkEnd(blkEnd), .bootHit(bootHit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneRdy[l]         = flashRdata[l*8 + 7];
    assign laneCodes[l*3 +: 3] = classify(flashRdata[l*8 +: 8]);
  end

  assign lanesReady = &laneRdy;
  assign timerDone  = (pollCnt == TW'(TMO_CYC - 1));
  assign anyError   = |errReg;
  assign walkEnd    = (blkEnd >= rangeHi);
  assign curWord    = curAddr[AW-1:WS];
  assign errCodes   = errReg;

  assign bootReject = bootProtect && ((geoCount == '0) || bootHit);
  assign inRange    = (curAddr >= rangeLo) && (curAddr < rangeHi);

  always_comb begin
    if (bootReject)                          checkCode = ERR_BOOT;
    else if (!inRange || blkStart != curAddr) checkCode = ERR_RANGE;
    else                                     checkCode = ERR_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      wholeMode <= 1'b0;
      pollCnt   <= '0;
      errReg    <= '0;
    end else begin
      if (ctl.loadReq) begin
        curAddr   <= wholeReq ? rangeLo : reqAddr;
        wholeMode <= wholeReq;
        errReg    <= '0;
      end else if (ctl.advance) begin
        curAddr <= blkEnd;
      end
      if (ctl.timerClr)      pollCnt <= '0;
      else if (ctl.timerInc) pollCnt <= pollCnt + 1'b1;
      if (ctl.takeReject)       errReg <= {LANES{3'(checkCode)}};
      else if (ctl.takeTimeout) errReg <= {LANES{3'(ERR_TIME)}};
      else if (ctl.takeStatus)  errReg <= laneCodes;
    end
  end

  // R3: poll counter never passes the timeout window
  assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < TW'(TMO_CYC));

  // R5: each walk step moves the target strictly upward
  assert_walk_upward_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> curAddr > $past(curAddr));

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  err_e               checkCode,
  input  logic               lanesReady,
  input  logic               timerDone,
  input  logic               anyError,
  input  logic               walkEnd,
  input  logic               wholeMode,
  output dp_strobe_t         ctl,
  output logic               flashWe,
  output logic               flashRe,
  output logic [8*LANES-1:0] flashWdata,
  output logic               vppEn,
  output logic               busy,
  output logic               done
);

  state_e     state, nxt;
  logic [7:0] cmd;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt     = state;
    ctl     = '0;
    flashWe = 1'b0;
    flashRe = 1'b0;
    cmd     = CMD_READ;
    case (state)
      S_IDLE: if (start) begin
        ctl.loadReq = 1'b1;
        nxt = S_CHECK;
      end
      S_CHECK: if (checkCode != ERR_NONE) begin
        ctl.takeReject = 1'b1;
        nxt = S_DONE;
      end else begin
        nxt = S_VPP;
      end
      S_VPP: nxt = S_SETUP;
      S_SETUP: begin
        flashWe = 1'b1;
        cmd = CMD_SETUP;
        nxt = S_CONFIRM;
      end
      S_CONFIRM: begin
        flashWe = 1'b1;
        cmd = CMD_CONFIRM;
        ctl.timerClr = 1'b1;
        nxt = S_POLL;
      end
      S_POLL: begin
        flashRe = 1'b1;
        if (lanesReady) begin
          ctl.takeStatus = 1'b1;
          nxt = S_CLEAR;
        end else if (timerDone) begin
          ctl.takeTimeout = 1'b1;
          nxt = S_CLEAR;
        end else begin
          ctl.timerInc = 1'b1;
        end
      end
      S_CLEAR: begin
        flashWe = 1'b1;
        cmd = CMD_CLEAR;
        nxt = S_READARR;
      end
      S_READARR: begin
        flashWe = 1'b1;
        cmd = CMD_READ;
        nxt = S_NEXT;
      end
      S_NEXT: if (anyError || !wholeMode || walkEnd) begin
        nxt = S_DONE;
      end else begin
        ctl.advance = 1'b1;
        nxt = S_VPP;
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign flashWdata = {LANES{cmd}};
  assign vppEn = (state == S_VPP) || (state == S_SETUP) ||
                 (state == S_CONFIRM) || (state == S_POLL);
  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);

  // R1: confirm is always directly preceded by setup
  assert_confirm_after_setup_R1: assert property (@(posedge clk) disable iff (!rstN)
    (flashWe && flashWdata == {LANES{CMD_CONFIRM}}) |->
      $past(flashWe && flashWdata == {LANES{CMD_SETUP}}));

  // R8: dropping the voltage enable coincides with the status-clear write
  assert_clear_on_vpp_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vppEn) |-> (flashWe && flashWdata == {LANES{CMD_CLEAR}}));

  // R9: done lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int AW         = 24,
  parameter int LANES      = 2,
  parameter int NREG       = 4,
  parameter int LOGW       = 5,
  parameter int CNTW       = 8,
  parameter int CLK_HZ     = 100_000_000,
  parameter int TIMEOUT_MS = 1500,
  localparam int CW        = $clog2(NREG + 1),
  localparam int WS        = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 wholeRange,
  input  logic [AW-1:0]        reqAddr,
  input  logic [AW-1:0]        rangeLo,
  input  logic [AW-1:0]        rangeHi,
  input  logic                 bootProtect,
  input  logic [CW-1:0]        geoCount,
  input  logic [NREG*LOGW-1:0] geoLog2,
  input  logic [NREG*CNTW-1:0] geoNum,
  output logic                 flashWe,
  output logic                 flashRe,
  output logic [AW-WS-1:0]     flashAddr,
  output logic [8*LANES-1:0]   flashWdata,
  input  logic [8*LANES-1:0]   flashRdata,
  output logic                 vppEn,
  output logic                 busy,
  output logic                 done,
  output logic [3*LANES-1:0]   errCodes
);

  localparam int TMO_CYC = CLK_HZ / 1000 * TIMEOUT_MS;

  dp_strobe_t ctl;
  err_e       checkCode;
  logic       lanesReady, timerDone, anyError, walkEnd, wholeMode;

  flash_erase_dp #(
    .AW(AW), .LANES(LANES), .NREG(NREG), .LOGW(LOGW), .CNTW(CNTW),
    .CW(CW), .TMO_CYC(TMO_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .wholeReq(wholeRange),
    .rangeLo(rangeLo), .rangeHi(rangeHi), .bootProtect(bootProtect),
    .geoCount(geoCount), .geoLog2(geoLog2), .geoNum(geoNum),
    .flashRdata(flashRdata), .curWord(flashAddr), .checkCode(checkCode),
    .lanesReady(lanesReady), .timerDone(timerDone), .anyError(anyError),
    .walkEnd(walkEnd), .wholeMode(wholeMode), .errCodes(errCodes)
  );

  flash_erase_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .checkCode(checkCode),
    .lanesReady(lanesReady), .timerDone(timerDone), .anyError(anyError),
    .walkEnd(walkEnd), .wholeMode(wholeMode), .ctl(ctl),
    .flashWe(flashWe), .flashRe(flashRe), .flashWdata(flashWdata),
    .vppEn(vppEn), .busy(busy), .done(done)
  );

endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;

  localparam int AW = 16, LANES = 2, NREG = 3, LOGW = 4, CNTW = 4, CW = 2;
  localparam int TMO = 30;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, wholeRange = 1'b0, bootProtect = 1'b0;
  logic [AW-1:0] reqAddr = '0, rangeLo = '0, rangeHi = '0;
  logic [CW-1:0] geoCount = 2'd3;
  logic [NREG*LOGW-1:0] geoLog2 = {4'd7, 4'd8, 4'd6};
  logic [NREG*CNTW-1:0] geoNum  = {4'd1, 4'd2, 4'd4};
  logic flashWe, flashRe, vppEn, busy, done;
  logic [AW-2:0] flashAddr;
  logic [15:0] flashWdata, flashRdata;
  logic [5:0] errCodes;

  flash_erase_seq #(
    .AW(AW), .LANES(LANES), .NREG(NREG), .LOGW(LOGW), .CNTW(CNTW),
    .CLK_HZ(10000), .TIMEOUT_MS(3)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .wholeRange(wholeRange),
    .reqAddr(reqAddr), .rangeLo(rangeLo), .rangeHi(rangeHi),
    .bootProtect(bootProtect), .geoCount(geoCount), .geoLog2(geoLog2),
    .geoNum(geoNum), .flashWe(flashWe), .flashRe(flashRe),
    .flashAddr(flashAddr), .flashWdata(flashWdata), .flashRdata(flashRdata),
    .vppEn(vppEn), .busy(busy), .done(done), .errCodes(errCodes)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  // ---------------- flash model ----------------
  int confirmTotal = 0, clearTotal = 0, raTotal = 0, readTotal = 0;
  int seqBad = 0, vppBad = 0, vppIdle = 0, elapsed = 0;
  int logAddr [64];
  logic [7:0] lastCmd = 8'h00;
  logic [AW-2:0] lastAddr = '0;
  logic armed = 1'b0;
  int delay0 = 3, delay1 = 3, injFrom = 1, opBase = 0;
  logic [7:0] inj0 = 8'h00, inj1 = 8'h00;
  logic [7:0] rd0, rd1;

  always @(posedge clk) begin
    if (flashWe) begin
      if (flashWdata == 16'h2020) begin
        if (!vppEn) vppBad <= vppBad + 1;
      end else if (flashWdata == 16'hD0D0) begin
        if (!vppEn || lastCmd != 8'h20 || lastAddr != flashAddr) seqBad <= seqBad + 1;
        logAddr[confirmTotal % 64] <= int'(flashAddr);
        confirmTotal <= confirmTotal + 1;
        armed <= 1'b1;
        elapsed <= 0;
      end else if (flashWdata == 16'h5050) begin
        if (vppEn) vppBad <= vppBad + 1;
        if (lastCmd != 8'hD0 || lastAddr != flashAddr) seqBad <= seqBad + 1;
        clearTotal <= clearTotal + 1;
      end else if (flashWdata == 16'hFFFF) begin
        if (lastCmd != 8'h50 || lastAddr != flashAddr || vppEn) seqBad <= seqBad + 1;
        raTotal <= raTotal + 1;
      end else begin
        seqBad <= seqBad + 1;
      end
      lastCmd <= flashWdata[7:0];
      lastAddr <= flashAddr;
    end else if (armed && elapsed < 5000) begin
      elapsed <= elapsed + 1;
    end
    if (flashRe) readTotal <= readTotal + 1;
    if (vppEn && !busy) vppIdle <= vppIdle + 1;
  end

  always_comb begin
    int k;
    k = confirmTotal - opBase;
    rd0 = (!armed || elapsed >= delay0) ? (8'h80 | ((k >= injFrom) ? inj0 : 8'h00)) : 8'h00;
    rd1 = (!armed || elapsed >= delay1) ? (8'h80 | ((k >= injFrom) ? inj1 : 8'h00)) : 8'h00;
    flashRdata = {rd1, rd0};
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int lgT [3] = '{6, 8, 7};
  int numT [3] = '{4, 2, 1};

  function automatic int bstart(input int a, input int nr);
    int base = 0;
    for (int r = 0; r < nr; r++) begin
      int sz = 1 << lgT[r];
      if (a >= base && a < base + numT[r]*sz) return base + ((a - base) / sz) * sz;
      base += numT[r]*sz;
    end
    return 65535;
  endfunction

  function automatic int bend(input int a, input int nr);
    int base = 0;
    for (int r = 0; r < nr; r++) begin
      int sz = 1 << lgT[r];
      if (a >= base && a < base + numT[r]*sz) return base + ((a - base) / sz + 1) * sz;
      base += numT[r]*sz;
    end
    return 65535;
  endfunction

  int resCodes, b0, dConf, dClr, dRa, dReads, dSeq, dVpp;
  int expAddr [16];

  task automatic runOp(input bit w, input int a, input int lo, input int hi,
                       input bit p, input int nr);
    int bClr, bRa, bRd, bSeq, bVpp, n;
    @(negedge clk);
    wholeRange = w; reqAddr = AW'(a); rangeLo = AW'(lo); rangeHi = AW'(hi);
    bootProtect = p; geoCount = CW'(nr);
    b0 = confirmTotal; bClr = clearTotal; bRa = raTotal; bRd = readTotal;
    bSeq = seqBad; bVpp = vppBad + vppIdle; opBase = confirmTotal;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    if (!done) chk("R9", "done pulse seen", 0, 1);
    resCodes = int'(errCodes);
    dConf = confirmTotal - b0; dClr = clearTotal - bClr; dRa = raTotal - bRa;
    dReads = readTotal - bRd; dSeq = seqBad - bSeq; dVpp = vppBad + vppIdle - bVpp;
  endtask

  function automatic int expCode(input int a, input int lo, input int hi,
                                 input bit p, input int nr);
    if (p && (nr == 0 || a < 64)) return 2;
    if (!(a >= lo && a < hi) || bstart(a, nr) != a) return 1;
    return 0;
  endfunction

  task automatic checkStd(input bit w, input int a, input int lo, input int hi,
                          input bit p, input int nr, input string req);
    int tgt, code, cnt, cur;
    tgt = w ? lo : a;
    code = expCode(tgt, lo, hi, p, nr);
    cnt = 0;
    if (code == 0) begin
      cur = tgt;
      do begin
        expAddr[cnt] = cur; cnt++;
        cur = bend(cur, nr);
      end while (w && cur < hi && cnt < 16);
    end
    runOp(w, a, lo, hi, p, nr);
    chk(req, "lane codes", resCodes, code * 9);
    chk(req, "erase count", dConf, cnt);
    for (int i = 0; i < cnt; i++)
      chk("R1", "erase word address", logAddr[(b0 + i) % 64], expAddr[i] >> 1);
    chk("R8", "clear writes", dClr, cnt);
    chk("R8", "read-array writes", dRa, cnt);
    chk("R1", "sequence/vpp violations", dSeq + dVpp, 0);
    chk("R2", "status reads", dReads, 4 * cnt);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "done", int'(done), 0);
    chk("R11", "vppEn", int'(vppEn), 0);
    chk("R11", "flashWe", int'(flashWe), 0);
    chk("R11", "flashRe", int'(flashRe), 0);
    chk("R11", "errCodes", int'(errCodes), 0);

    // single-block sweep over the table, both protect settings
    for (int p = 0; p < 2; p++)
      for (int a = 0; a <= 960; a += 16)
        checkStd(0, a, 0, 896, p[0], 3, (expCode(a, 0, 896, p[0], 3) == 2) ? "R6" : "R4");
    checkStd(0, 512, 256, 768, 0, 3, "R4");
    checkStd(0, 128, 256, 768, 0, 3, "R4");
    checkStd(0, 768, 0, 896, 0, 2, "R4");
    checkStd(0, 0, 0, 896, 0, 0, "R4");
    checkStd(0, 512, 0, 896, 1, 0, "R6");

    // range walks
    checkStd(1, 0, 64, 896, 1, 3, "R5");
    checkStd(1, 0, 0, 896, 0, 3, "R5");
    checkStd(1, 0, 0, 896, 1, 3, "R6");
    checkStd(1, 0, 128, 512, 0, 3, "R5");
    checkStd(1, 0, 100, 512, 0, 3, "R4");
    checkStd(1, 0, 256, 768, 1, 3, "R5");
    checkStd(1, 0, 768, 896, 0, 3, "R5");
    checkStd(1, 0, 512, 512, 0, 3, "R4");

    // interleaved ready: both lanes must be ready
    delay0 = 2; delay1 = 5;
    runOp(0, 256, 0, 896, 0, 3);
    chk("R2", "reads lane1 slow", dReads, 6);
    delay0 = 7; delay1 = 1;
    runOp(0, 256, 0, 896, 0, 3);
    chk("R2", "reads lane0 slow", dReads, 8);
    delay0 = 3; delay1 = 3;

    // status classification per lane
    inj0 = 8'h0A; inj1 = 8'h28;
    runOp(0, 256, 0, 896, 0, 3);
    chk("R7", "lock vs volt lanes", resCodes, (4 << 3) | 3);
    inj0 = 8'h30; inj1 = 8'h00;
    runOp(0, 256, 0, 896, 0, 3);
    chk("R7", "fail lane0 only", resCodes, 5);
    inj0 = 8'h10; inj1 = 8'h22;
    runOp(0, 512, 0, 896, 0, 3);
    chk("R7", "lock beats fail", resCodes, (3 << 3) | 5);
    chk("R8", "clear after error", dClr, 1);
    repeat (10) @(negedge clk);
    chk("R9", "codes held while idle", int'(errCodes), (3 << 3) | 5);
    inj0 = 8'h08; inj1 = 8'h00;
    runOp(0, 768, 0, 896, 0, 3);
    chk("R7", "low voltage", resCodes, 4);

    // walk stops at first failing block
    inj0 = 8'h00; inj1 = 8'h20; injFrom = 3;
    runOp(1, 0, 64, 896, 1, 3);
    chk("R9", "walk stop count", dConf, 3);
    chk("R9", "walk stop codes", resCodes, 5 << 3);
    chk("R9", "last erased word", logAddr[(b0 + 2) % 64], 192 >> 1);
    inj1 = 8'h00; injFrom = 1;

    // timeout
    delay1 = 4000;
    runOp(0, 256, 0, 896, 0, 3);
    chk("R3", "timeout codes", resCodes, 6 * 9);
    chk("R3", "timeout reads", dReads, TMO);
    chk("R8", "clear after timeout", dClr, 1);
    runOp(1, 0, 64, 896, 0, 3);
    chk("R3", "walk stops on timeout", dConf, 1);
    delay1 = 3;
    repeat (5) @(negedge clk);

    // start while busy is ignored
    @(negedge clk);
    wholeRange = 1'b1; rangeLo = 16'd64; rangeHi = 16'd896; bootProtect = 1'b1;
    geoCount = 2'd3; b0 = confirmTotal; opBase = confirmTotal;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    wholeRange = 1'b0; reqAddr = 16'd768; start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int n = 0;
      while (!done && n < 3000) begin @(negedge clk); n++; end
    end
    chk("R10", "erase count with stray start", confirmTotal - b0, 6);
    chk("R10", "first block kept", logAddr[b0 % 64], 64 >> 1);
    chk("R10", "result", int'(errCodes), 0);
    @(negedge clk);
    chk("R9", "done dropped", int'(done), 0);
    chk("R10", "idle after walk", int'(busy), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule